// File: doc/BRIEF.md
# Cell Balancing Bypass Timer Bank

This block runs the timed part of cell balancing for a series battery stack of up to four cells. Each cell has a bypass switch. Each cell also supplies the charge, in mAh, that it still needs to reach full. When a balancing run is requested, the block finds the cell with the largest remaining need. It subtracts each cell's own need from that maximum to get the cell's charge difference. It then loads a per-cell countdown with the difference multiplied by a configured scale factor in seconds per mAh. The bypass resistance, the cell voltage and the duty cycle are already folded into that factor, so the product is the bypass time in seconds.

While a cell's countdown is nonzero, its bypass switch is on. A one-second tick enable counts every running countdown down. A status output shows whether any switch is on. A scale factor of zero turns balancing off completely. A request that arrives while any countdown is still running is dropped. A duration too large for the counter width is clamped to the largest count.

Top module: `cell_bal_timer_bank`

## Requirements
- R1: After reset every bypass switch is off and `bal_active` is 0.
- R2: A start request is accepted on a clock edge where `start_req` is 1, no countdown is running and `scale_s_per_mah` is nonzero. At that edge, cell i loads (max need − need of cell i) × scale. Its bypass bit (bit i of `bypass_on`, cell i at need slice [16i+15:16i]) is on from the next cycle exactly when that value is nonzero.
- R3: The cell with the largest need is never bypassed. When several cells share the maximum, none of them is bypassed.
- R4: Each running countdown drops by one on every clock edge where `tick_1s` is 1. A cell loaded with D stays bypassed for exactly D ticks.
- R5: `bal_active` is 1 exactly when at least one bit of `bypass_on` is 1.
- R6: When the scale factor is zero, a start request is ignored and no bypass switch turns on.
- R7: A start request made while any countdown is nonzero is ignored. The running counts and switches carry on unchanged.
- R8: A product larger than 2^TMR_W − 1 is loaded as 2^TMR_W − 1.
- R9: Without a tick or an accepted start, the switches do not change. A tick on the same edge as an accepted start does not decrement the freshly loaded counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1s | input | 1 | One-second count enable, one cycle wide |
| start_req | input | 1 | Request to start a balancing run |
| scale_s_per_mah | input | SCL_W | Bypass seconds per mAh of charge difference; 0 disables balancing |
| need_mah | input | NCELL*CHG_W | Per-cell remaining charge to full, cell i in slice [CHG_W*i +: CHG_W] |
| bypass_on | output | NCELL | Bypass switch enables, bit i for cell i |
| bal_active | output | 1 | Any bypass switch on |

## Verification
The bench targets the following corner cases:

- **Tied maximum.** Two cells share the largest need. A design that picked only one of them as the reference, or compared the wrong way, would bypass a full cell.
- **Start in the same cycle as a tick.** A design that decremented after loading would cut one second from every cell.
- **Start while busy.** A design that reloaded mid-run would show changed switch patterns.
- **Zero scale.** A design without the zero-scale check would still arm its timers, though only for zero counts.
- **Saturating product.** The bench uses a narrowed counter. A design that wrapped the product would release the cell early; the bench counts ticks until the release and compares with the clamped value.

// File: rtl/cb_pkg.sv
package cb_pkg;

  // Saturating product used to turn a charge difference into a bypass time.
  function automatic logic [63:0] cb_sat_mul(input logic [63:0] a,
                                             input logic [63:0] b,
                                             input int unsigned tw);
    logic [63:0] prod;
    logic [63:0] lim;
    prod = a * b;
    lim  = (64'd1 << tw) - 64'd1;
    return (prod > lim) ? lim : prod;
  endfunction

endpackage

// File: rtl/cb_max_pick.sv
module cb_max_pick #(
  parameter int NCELL = 4,
  parameter int CHG_W = 16
) (
  input  logic [NCELL*CHG_W-1:0] need_mah,
  output logic [CHG_W-1:0]       max_val,
  output logic [NCELL-1:0]       max_oh
);
  // Lowest index wins a tie; the reference cell's difference is zero anyway.
  always_comb begin
    max_val = need_mah[CHG_W-1:0];
    max_oh  = '0;
    max_oh[0] = 1'b1;
    for (int i = 1; i < NCELL; i++) begin
      if (need_mah[CHG_W*i +: CHG_W] > max_val) begin
        max_val   = need_mah[CHG_W*i +: CHG_W];
        max_oh    = '0;
        max_oh[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cb_cell_timer.sv
module cb_cell_timer #(
  parameter int TMR_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  input  logic             tick,
  output logic             run
);
  logic [TMR_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (tick && cnt != '0) cnt <= cnt - TMR_W'(1);
  end

  assign run = (cnt != '0);
endmodule

// File: rtl/cell_bal_timer_bank.sv
module cell_bal_timer_bank #(
  parameter int NCELL = 4,
  parameter int CHG_W = 16,
  parameter int SCL_W = 8,
  parameter int TMR_W = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_1s,
  input  logic                   start_req,
  input  logic [SCL_W-1:0]       scale_s_per_mah,
  input  logic [NCELL*CHG_W-1:0] need_mah,
  output logic [NCELL-1:0]       bypass_on,
  output logic                   bal_active
);
  import cb_pkg::*;

  logic [CHG_W-1:0] max_val;
  logic [NCELL-1:0] max_oh;
  logic             busy;
  logic             scale_ok;
  logic             load_evt;

  cb_max_pick #(.NCELL(NCELL), .CHG_W(CHG_W)) u_max (
    .need_mah (need_mah),
    .max_val  (max_val),
    .max_oh   (max_oh)
  );

  assign busy     = |bypass_on;
  assign scale_ok = (scale_s_per_mah != '0);
  assign load_evt = start_req && !busy && scale_ok;

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    logic [CHG_W-1:0] diff;
    logic [TMR_W-1:0] dur;
    assign diff = max_val - need_mah[CHG_W*i +: CHG_W];
    assign dur  = TMR_W'(cb_sat_mul(64'(diff), 64'(scale_s_per_mah), TMR_W));
    cb_cell_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_evt),
      .load_val (dur),
      .tick     (tick_1s),
      .run      (bypass_on[i])
    );
  end

  assign bal_active = busy;
endmodule

// File: rtl/cb_bank_chk.sv
module cb_bank_chk #(
  parameter int NCELL = 4,
  parameter int SCL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_1s,
  input logic [SCL_W-1:0] scale_s_per_mah,
  input logic [NCELL-1:0] bypass_on,
  input logic             bal_active,
  input logic             load_evt,
  input logic [NCELL-1:0] max_oh
);
  p_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bal_active == (bypass_on != '0));

  p_zero_scale_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_on == '0 && scale_s_per_mah == '0) |=> (bypass_on == '0));

  p_busy_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_on != '0) |-> !load_evt);

  p_max_never_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> ((bypass_on & $past(max_oh)) == '0));

  p_no_spont_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> ((bypass_on & ~$past(bypass_on)) == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1s && !load_evt) |=> $stable(bypass_on));
endmodule

bind cell_bal_timer_bank cb_bank_chk #(.NCELL(NCELL), .SCL_W(SCL_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .tick_1s         (tick_1s),
  .scale_s_per_mah (scale_s_per_mah),
  .bypass_on       (bypass_on),
  .bal_active      (bal_active),
  .load_evt        (load_evt),
  .max_oh          (max_oh)
);

// File: tb/cell_bal_timer_bank_test.sv
module cell_bal_timer_bank_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NC = 4;
  localparam int QW = 16;
  localparam int SW = 8;
  localparam int TW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1s = 1'b0;
  logic start_req = 1'b0;
  logic [SW-1:0] scale = '0;
  logic [NC*QW-1:0] need = '0;
  logic [NC-1:0] bypass_on;
  logic bal_active;

  int total = 0;
  int bad = 0;
  longint m_cnt [NC];

  always #2.5 clk = ~clk;

  cell_bal_timer_bank #(.NCELL(NC), .CHG_W(QW), .SCL_W(SW), .TMR_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .start_req(start_req),
    .scale_s_per_mah(scale), .need_mah(need),
    .bypass_on(bypass_on), .bal_active(bal_active));

  task automatic set_need(input int n0, input int n1, input int n2, input int n3);
    need = {QW'(n3), QW'(n2), QW'(n1), QW'(n0)};
  endtask

  // Bench model of one clock edge, written from the requirements.
  task automatic cyc(input bit tk, input bit st);
    bit run;
    longint mx;
    longint lim;
    start_req = st;
    tick_1s   = tk;
    @(posedge clk);
    run = 0;
    for (int i = 0; i < NC; i++) if (m_cnt[i] != 0) run = 1;
    if (st && !run && scale != 0) begin
      mx = 0;
      for (int i = 0; i < NC; i++) if (longint'(need[QW*i +: QW]) > mx) mx = need[QW*i +: QW];
      lim = (longint'(1) << TW) - 1;
      for (int i = 0; i < NC; i++) begin
        m_cnt[i] = (mx - longint'(need[QW*i +: QW])) * longint'(scale);
        if (m_cnt[i] > lim) m_cnt[i] = lim;
      end
    end else if (tk) begin
      for (int i = 0; i < NC; i++) if (m_cnt[i] != 0) m_cnt[i]--;
    end
    @(negedge clk);
    start_req = 1'b0;
    tick_1s   = 1'b0;
  endtask

  task automatic check(input string tag);
    logic [NC-1:0] exp_b;
    for (int i = 0; i < NC; i++) exp_b[i] = (m_cnt[i] != 0);
    total++;
    if (bypass_on !== exp_b || bal_active !== (exp_b != '0)) begin
      bad++;
      $display("FAIL %s: bypass=%b active=%b expected bypass=%b active=%b",
               tag, bypass_on, bal_active, exp_b, (exp_b != '0));
    end
  endtask

  task automatic check_bits(input string tag, input logic [NC-1:0] want);
    total++;
    if (bypass_on !== want) begin
      bad++;
      $display("FAIL %s: bypass=%b expected %b", tag, bypass_on, want);
    end
  endtask

  task automatic t_reset;
    for (int i = 0; i < NC; i++) m_cnt[i] = 0;
    check_bits("R1 reset", 4'b0000);
    check("R1 R5 reset status");
  endtask

  task automatic t_basic;
    scale = 8'd1;
    set_need(10, 13, 12, 10);
    cyc(0, 1);
    check_bits("R2 R3 load pattern", 4'b1101);
    check("R5 active after load");
    cyc(0, 0); cyc(0, 0);
    check_bits("R9 hold without tick", 4'b1101);
    cyc(1, 0);
    check_bits("R4 first tick", 4'b1001);
    set_need(0, 0, 50, 0);
    cyc(0, 1);
    check_bits("R7 start while busy ignored", 4'b1001);
    cyc(1, 0);
    check("R4 R7 second tick");
    cyc(1, 0);
    check_bits("R4 run ends after 3 ticks", 4'b0000);
    check("R5 inactive after run");
  endtask

  task automatic t_tie_scale;
    scale = 8'd3;
    set_need(5, 0, 2, 5);
    cyc(0, 1);
    check_bits("R3 tied max cells not bypassed", 4'b0110);
    for (int k = 0; k < 8; k++) cyc(1, 0);
    check_bits("R4 after 8 ticks", 4'b0110);
    cyc(1, 0);
    check_bits("R4 cell2 off after 9 ticks", 4'b0010);
    for (int k = 0; k < 6; k++) cyc(1, 0);
    check_bits("R4 cell1 off after 15 ticks", 4'b0000);
  endtask

  task automatic t_zero_scale;
    scale = 8'd0;
    set_need(1, 40, 7, 3);
    cyc(0, 1);
    check_bits("R6 zero scale start ignored", 4'b0000);
    cyc(1, 1);
    check("R6 R9 idle tick with zero scale");
  endtask

  task automatic t_tick_with_start;
    scale = 8'd1;
    set_need(4, 3, 4, 4);
    cyc(1, 1);
    check_bits("R9 tick on load edge not applied", 4'b0010);
    cyc(1, 0);
    check_bits("R4 one-second run ends", 4'b0000);
  endtask

  task automatic t_saturate;
    int n1;
    int n2;
    scale = 8'hFF;
    set_need(16'hFFFF, 0, 16'hFFEF, 16'hFFFF);
    cyc(0, 1);
    check_bits("R8 R2 load pattern", 4'b0110);
    n1 = 0; n2 = 0;
    for (int k = 1; k <= 5000 && bypass_on != '0; k++) begin
      cyc(1, 0);
      if (!bypass_on[2] && n2 == 0) n2 = k;
      if (!bypass_on[1] && n1 == 0) n1 = k;
    end
    total++;
    if (n2 != 4080) begin
      bad++; $display("FAIL R2 unsaturated duration: %0d expected 4080", n2);
    end
    total++;
    if (n1 != 4095) begin
      bad++; $display("FAIL R8 saturated duration: %0d expected 4095", n1);
    end
    check("R8 end state");
  endtask

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_tie_scale();
    t_zero_scale();
    t_tick_with_start();
    t_saturate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule